// File: doc/BRIEF.md
# Fractional Baud Tick Generator

This block turns the system clock into an oversampling tick and a bit-rate tick for a serial port. The divisor has a 16-bit integer part and a 6-bit fraction counted in 1/64 steps. A 6-bit phase accumulator spreads the fraction across periods. Each oversampling period lasts either the integer count of clocks or one clock more. Over 64 periods the average period comes to integer + fraction/64 clocks.

Software writes the integer and the fraction into staging registers. Neither staged value reaches the divider until a write to the line-control register. That write moves both staged parts and the line-control byte into the active set in one step, and it restarts the divider. A plain high-speed input selects the oversampling ratio: 16 when clear, 8 when set. A smart-card input overrides it and forces 16. The bit tick marks every 16th or 8th oversampling tick.

There is no data stream, so all pins are plain control and status.

Top module: `baud_tick_gen`

## Requirements
- R1: After reset `os_tick` and `bit_tick` are low, the active divisor is zero (no ticks are produced), and `lc_active` is 0x00.
- R2: Let f be the active fraction (value f means f/64) and I the active integer. Oversampling period k (k = 0, 1, ...) lasts I + c_k clocks. Here c_k is 1 when (a_k + f) >= 64, else 0. The accumulator starts at a_0 = 0 and updates as a_{k+1} = (a_k + f) mod 64.
- R3: While the active integer divisor is 0, `os_tick` and `bit_tick` stay low.
- R4: Writes on the integer or fraction ports change no tick timing until a line-control write follows.
- R5: A line-control write makes the last staged integer and fraction active together with `lc_wdata` (seen on `lc_active` after that edge). This holds whether one or both parts were written, in either order.
- R6: A line-control write restarts the divider. The first `os_tick` rises I + c_0 clocks after the committing edge.
- R7: With an active integer of at least 2, every `os_tick` pulse lasts exactly one clock.
- R8: `bit_tick` coincides with every 16th `os_tick` after a commit when `hs_en` = 0, and with every 8th when `hs_en` = 1. It is never high without `os_tick`.
- R9: When `smart_en` = 1 the ratio is 16 regardless of `hs_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| int_we | input | 1 | Write strobe for the staged integer divisor |
| int_wdata | input | 16 | Integer divisor value |
| frac_we | input | 1 | Write strobe for the staged fraction |
| frac_wdata | input | 6 | Fraction in 1/64 units |
| lc_we | input | 1 | Line-control write strobe; commits the divisor |
| lc_wdata | input | 8 | Line-control byte |
| hs_en | input | 1 | 1 selects 8x oversampling, 0 selects 16x |
| smart_en | input | 1 | Smart-card mode; forces 16x |
| os_tick | output | 1 | Oversampling tick |
| bit_tick | output | 1 | Bit-rate tick |
| lc_active | output | 8 | Committed line-control byte |

## Verification
The assertions assume that a staging write and a line-control write never land in the same cycle. In that case the commit would take the older staged value. The bench keeps every write strobe in its own clock cycle to stay clear of that case. The assertions also assume that `hs_en` and `smart_en` change only between commits. The bench sets them before each commit and leaves them alone while it counts ticks. The stimulus sweeps every fraction value at one integer divisor and samples fractions at two others. Expected tick times come from the accumulator arithmetic of R2.

// File: rtl/baud_tick_pkg.sv
package baud_tick_pkg;
  localparam int unsigned INT_W  = 16;
  localparam int unsigned FRAC_W = 6;
  localparam int unsigned LC_W   = 8;
  localparam int unsigned OS_LO  = 8;
  localparam int unsigned OS_HI  = 16;

  typedef enum logic {
    OS_RATIO_16 = 1'b0,
    OS_RATIO_8  = 1'b1
  } os_ratio_e;
endpackage

// File: rtl/baud_div_regs.sv
module baud_div_regs #(
  parameter int unsigned INT_W  = 16,
  parameter int unsigned FRAC_W = 6,
  parameter int unsigned LC_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              int_we,
  input  logic [INT_W-1:0]  int_wdata,
  input  logic              frac_we,
  input  logic [FRAC_W-1:0] frac_wdata,
  input  logic              lc_we,
  input  logic [LC_W-1:0]   lc_wdata,
  output logic [INT_W-1:0]  div_int,
  output logic [FRAC_W-1:0] div_frac,
  output logic [LC_W-1:0]   lc_q,
  output logic              commit
);
  logic [INT_W-1:0]  stage_int;
  logic [FRAC_W-1:0] stage_frac;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_int  <= '0;
      stage_frac <= '0;
    end else begin
      if (int_we)  stage_int  <= int_wdata;
      if (frac_we) stage_frac <= frac_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_int  <= '0;
      div_frac <= '0;
      lc_q     <= '0;
    end else if (lc_we) begin
      div_int  <= stage_int;
      div_frac <= stage_frac;
      lc_q     <= lc_wdata;
    end
  end

  assign commit = lc_we;

  // R4
  hold_div_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lc_we |=> ($stable(div_int) && $stable(div_frac)));

  // R5
  commit_lc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lc_we |=> (lc_q == $past(lc_wdata)));
endmodule

// File: rtl/baud_frac_div.sv
module baud_frac_div #(
  parameter int unsigned INT_W  = 16,
  parameter int unsigned FRAC_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit,
  input  logic [INT_W-1:0]  div_int,
  input  logic [FRAC_W-1:0] div_frac,
  output logic              os_fire,
  output logic              os_tick
);
  localparam int unsigned LEN_W = INT_W + 1;

  logic [INT_W-1:0]  cnt;
  logic [FRAC_W-1:0] acc;
  logic [FRAC_W:0]   acc_sum;
  logic              carry;
  logic [LEN_W-1:0]  len;
  logic              run;

  always_comb begin
    acc_sum = {1'b0, acc} + {1'b0, div_frac};
    carry   = acc_sum[FRAC_W];
    len     = {1'b0, div_int} + {{INT_W{1'b0}}, carry};
    run     = (div_int != '0);
    os_fire = run && ({1'b0, cnt} == (len - LEN_W'(1)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      acc     <= '0;
      os_tick <= 1'b0;
    end else if (commit || !run) begin
      cnt     <= '0;
      acc     <= '0;
      os_tick <= 1'b0;
    end else if (os_fire) begin
      cnt     <= '0;
      acc     <= acc_sum[FRAC_W-1:0];
      os_tick <= 1'b1;
    end else begin
      cnt     <= cnt + INT_W'(1);
      os_tick <= 1'b0;
    end
  end

  // R3
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (div_int == '0) |-> !os_tick);

  // R7
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (os_tick && div_int >= INT_W'(2)) |=> !os_tick);

  // R6
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !os_tick);
endmodule

// File: rtl/baud_bit_div.sv
module baud_bit_div
  import baud_tick_pkg::*;
#(
  parameter int unsigned RATIO_LO = OS_LO,
  parameter int unsigned RATIO_HI = OS_HI
) (
  input  logic clk,
  input  logic rst_n,
  input  logic commit,
  input  logic os_fire,
  input  logic hs_en,
  input  logic smart_en,
  output logic bit_tick
);
  localparam int unsigned SUB_W = $clog2(RATIO_HI);

  os_ratio_e        ratio;
  logic [SUB_W-1:0] sub;
  logic [SUB_W-1:0] last;
  logic             wrap;

  always_comb begin
    ratio = (hs_en && !smart_en) ? OS_RATIO_8 : OS_RATIO_16;
    last  = (ratio == OS_RATIO_8) ? SUB_W'(RATIO_LO - 1) : SUB_W'(RATIO_HI - 1);
    wrap  = (sub >= last);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sub      <= '0;
      bit_tick <= 1'b0;
    end else if (commit) begin
      sub      <= '0;
      bit_tick <= 1'b0;
    end else if (os_fire) begin
      sub      <= wrap ? '0 : sub + SUB_W'(1);
      bit_tick <= wrap;
    end else begin
      bit_tick <= 1'b0;
    end
  end

  // R8
  sub_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sub <= SUB_W'(RATIO_HI - 1));
endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
  import baud_tick_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              int_we,
  input  logic [INT_W-1:0]  int_wdata,
  input  logic              frac_we,
  input  logic [FRAC_W-1:0] frac_wdata,
  input  logic              lc_we,
  input  logic [LC_W-1:0]   lc_wdata,
  input  logic              hs_en,
  input  logic              smart_en,
  output logic              os_tick,
  output logic              bit_tick,
  output logic [LC_W-1:0]   lc_active
);
  logic [INT_W-1:0]  div_int;
  logic [FRAC_W-1:0] div_frac;
  logic              commit;
  logic              os_fire;

  baud_div_regs #(.INT_W(INT_W), .FRAC_W(FRAC_W), .LC_W(LC_W)) regs_i (
    .clk(clk), .rst_n(rst_n),
    .int_we(int_we), .int_wdata(int_wdata),
    .frac_we(frac_we), .frac_wdata(frac_wdata),
    .lc_we(lc_we), .lc_wdata(lc_wdata),
    .div_int(div_int), .div_frac(div_frac), .lc_q(lc_active), .commit(commit)
  );

  baud_frac_div #(.INT_W(INT_W), .FRAC_W(FRAC_W)) frac_i (
    .clk(clk), .rst_n(rst_n), .commit(commit),
    .div_int(div_int), .div_frac(div_frac),
    .os_fire(os_fire), .os_tick(os_tick)
  );

  baud_bit_div #(.RATIO_LO(OS_LO), .RATIO_HI(OS_HI)) bit_i (
    .clk(clk), .rst_n(rst_n), .commit(commit), .os_fire(os_fire),
    .hs_en(hs_en), .smart_en(smart_en), .bit_tick(bit_tick)
  );

  // R8
  bit_in_os_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |-> os_tick);
endmodule

// File: tb/baud_tick_gen_tb_top.sv
module baud_tick_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        int_we = 1'b0;
  logic [15:0] int_wdata = '0;
  logic        frac_we = 1'b0;
  logic [5:0]  frac_wdata = '0;
  logic        lc_we = 1'b0;
  logic [7:0]  lc_wdata = '0;
  logic        hs_en = 1'b0;
  logic        smart_en = 1'b0;
  logic        os_tick;
  logic        bit_tick;
  logic [7:0]  lc_active;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  baud_tick_gen dut_i (
    .clk(clk), .rst_n(rst_n),
    .int_we(int_we), .int_wdata(int_wdata),
    .frac_we(frac_we), .frac_wdata(frac_wdata),
    .lc_we(lc_we), .lc_wdata(lc_wdata),
    .hs_en(hs_en), .smart_en(smart_en),
    .os_tick(os_tick), .bit_tick(bit_tick), .lc_active(lc_active)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr_int(input int v);
    @(negedge clk); int_wdata = 16'(v); int_we = 1'b1;
    @(negedge clk); int_we = 1'b0;
  endtask

  task automatic wr_frac(input int v);
    @(negedge clk); frac_wdata = 6'(v); frac_we = 1'b1;
    @(negedge clk); frac_we = 1'b0;
  endtask

  // ends on the negedge right after the committing posedge
  task automatic wr_lc(input int v);
    @(negedge clk); lc_wdata = 8'(v); lc_we = 1'b1;
    @(negedge clk); lc_we = 1'b0;
  endtask

  // Collect n os ticks after a commit; compare times to the R2 accumulator model
  task automatic measure(input int iv, input int fv, input int n,
                         output int first_bad, output int got, output int want,
                         output int nbit, output int orphan);
    int exp_t[64];
    int acc = 0;
    int t = 0;
    int idx = 0;
    int c = 0;
    for (int k = 0; k < n; k++) begin
      int cy = ((acc + fv) >= 64) ? 1 : 0;
      t += iv + cy;
      acc = (acc + fv) % 64;
      exp_t[k] = t;
    end
    first_bad = -1; got = 0; want = 0; nbit = 0; orphan = 0;
    while (idx < n && c < exp_t[n-1] + 8) begin
      @(negedge clk);
      c++;
      if (bit_tick && !os_tick) orphan++;
      if (os_tick) begin
        if (bit_tick) nbit++;
        if (first_bad < 0 && c != exp_t[idx]) begin
          first_bad = idx; got = c; want = exp_t[idx];
        end
        idx++;
      end
    end
    if (idx < n && first_bad < 0) begin
      first_bad = idx; got = -1; want = exp_t[idx];
    end
  endtask

  task automatic run_cfg(input int iv, input int fv, input bit hs, input bit sm, input string req);
    int fb, g, w, nb, orp, ratio;
    hs_en = hs; smart_en = sm;
    wr_int(iv);
    wr_frac(fv);
    wr_lc(8'h5A ^ fv);
    measure(iv, fv, 32, fb, g, w, nb, orp);
    check(fb < 0, req, g, w);
    ratio = (hs && !sm) ? 8 : 16;
    check(nb == 32 / ratio && orp == 0, "R8", nb, 32 / ratio);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin : main
    int fb, g, w, nb, orp;
    int cnt;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(os_tick == 1'b0 && bit_tick == 1'b0, "R1", os_tick, 0);
    check(lc_active == 8'h00, "R1", lc_active, 0);
    rst_n = 1'b1;
    cnt = 0;
    for (int i = 0; i < 100; i++) begin @(negedge clk); if (os_tick) cnt++; end
    check(cnt == 0, "R1", cnt, 0);

    // R2 full fraction sweep at integer 2, R6 restart for each commit
    for (int f = 0; f < 64; f++) run_cfg(2, f, f[0], 1'b0, "R2");
    for (int f = 0; f < 64; f += 9) run_cfg(1, f, 1'b0, 1'b0, "R2");
    for (int f = 1; f < 64; f += 9) run_cfg(5, f, 1'b1, 1'b0, "R6");

    // R9 smart-card forces 16 even with hs_en
    run_cfg(3, 20, 1'b1, 1'b1, "R9");

    // R7 pulse width at integer 2 frac 63
    wr_int(2); wr_frac(63); wr_lc(1);
    cnt = 0;
    begin
      bit prev = 1'b0;
      for (int i = 0; i < 200; i++) begin
        @(negedge clk);
        if (prev && os_tick) cnt++;
        prev = os_tick;
      end
    end
    check(cnt == 0, "R7", cnt, 0);

    // R4 staged writes do not change timing; R5 lc byte
    wr_int(4); wr_frac(0); wr_lc(8'hC3);
    check(lc_active == 8'hC3, "R5", lc_active, 8'hC3);
    wr_frac(32); wr_int(2);
    wr_lc(8'h3C);
    // now 2 + 32/64: check; before that verify staging isolation separately
    measure(2, 32, 32, fb, g, w, nb, orp);
    check(fb < 0, "R5", g, w);
    wr_int(4); wr_frac(0); wr_lc(8'h11);
    wr_int(2); wr_frac(40);
    measure(4, 0, 16, fb, g, w, nb, orp);
    check(fb < 0, "R4", g, w);
    check(lc_active == 8'h11, "R4", lc_active, 8'h11);
    // only fraction staged then commit: integer 2 staged earlier stays
    wr_frac(10); wr_lc(8'h22);
    measure(2, 10, 32, fb, g, w, nb, orp);
    check(fb < 0, "R5", g, w);
    check(lc_active == 8'h22, "R5", lc_active, 8'h22);

    // R3 integer zero disables ticks
    wr_int(0); wr_frac(17); wr_lc(0);
    cnt = 0;
    for (int i = 0; i < 300; i++) begin @(negedge clk); if (os_tick || bit_tick) cnt++; end
    check(cnt == 0, "R3", cnt, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule